// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single line that software must keep toggling. If no transition reaches the block for a whole timeout window, it drives an active-low alarm output. Rising and falling transitions both restart the window. The line is first passed through a flop synchroniser, so a transition takes effect a fixed number of clocks after it arrives. The window length is a parameter given in clock cycles. Its default equals 1.6 s at the configured clock frequency, and it must be at least two cycles.

A separate synchronous flag marks the line as undriven (floating or high impedance). While this flag is set, the watchdog is idle and cannot time out. When the flag clears, counting starts again from zero. Recognising a floating line electrically is left to logic outside this block.

The block also takes a supply-good flag and the reset-active signal from the system reset generator. An active reset clears the window. While the supply is bad, the alarm output is forced low. The output is released in the same cycle that the supply recovers. The block has no streaming data path: every pin is a plain level signal with no handshake, so back-pressure does not apply.

Top module: `wdt_edge_watchdog`

## Requirements
- R1: With `wdi_float`, `sys_rst` and `wdi` all steady, `wdo_n` goes low after TIMEOUT_CYC clock edges without a clear. A clear is a synchronised transition, an active reset, a floating cycle or the first cycle after floating.
- R2: A low-to-high change on `wdi` restarts the count and releases an expired alarm.
- R3: A high-to-low change on `wdi` restarts the count and releases an expired alarm, in the same way as a rising change.
- R4: While `sys_rst` is 1, the count is held at zero and the alarm is released. No timeout occurs for as long as `sys_rst` stays at 1.
- R5: While `wdi_float` is 1, the watchdog is idle and never times out, even if `wdi` does not change.
- R6: After a timeout, `wdo_n` stays low until a clear occurs.
- R7: While `supply_ok` is 0, `wdo_n` is 0.
- R8: When `supply_ok` returns to 1 and the timer has not expired, `wdo_n` goes to 1 in the same cycle, with no extra delay.
- R9: A change on `wdi` set up before clock edge k clears the timer at edge k+2 with the default two synchroniser stages. This is the two-flop synchroniser followed by a one-flop edge detector.
- R10: The first clock edge after `wdi_float` falls restarts the count from zero, so a full TIMEOUT_CYC window follows.
- R11: While `rst_n` is 0 and `supply_ok` is 1, `wdo_n` is 1. After `rst_n` is released, the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wdi | input | 1 | Line that software toggles; may be asynchronous |
| wdi_float | input | 1 | Synchronous flag: line is floating, watchdog idle |
| supply_ok | input | 1 | Supply above threshold |
| sys_rst | input | 1 | System reset active, high |
| wdo_n | output | 1 | Watchdog alarm, active low |

## Verification
The window is shortened to five cycles. The line is then toggled at every gap length from one to eight cycles. This shows that gaps shorter than the window never fire, that longer gaps fire after exactly five quiet edges, and that rising and falling changes clear the timer in the same way. Single changes after an expiry measure the two-edge synchroniser latency, cycle by cycle. Separate phases hold reset, hold the floating flag and drop the supply. These phases distinguish the three ways of silencing the alarm: clearing, idling and forcing it low. A zero-delay check confirms that the output is released as soon as the supply recovers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_SYNC_DEFAULT = 2;

  typedef enum logic [1:0] {
    WD_IDLE    = 2'd0,
    WD_COUNT   = 2'd1,
    WD_EXPIRED = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic toggled
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  // either direction counts as activity
  assign toggled = level ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 5,
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          clear,
  output logic          expired,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  wd_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_COUNT;
      cnt_q   <= '0;
    end else if (idle) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else if (clear) begin
      state_q <= WD_COUNT;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          // leaving idle restarts the window
          state_q <= WD_COUNT;
          cnt_q   <= '0;
        end
        WD_COUNT: begin
          if (cnt_q == LAST) state_q <= WD_EXPIRED;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        WD_EXPIRED: state_q <= WD_EXPIRED;
        default: begin
          state_q <= WD_COUNT;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign expired = (state_q == WD_EXPIRED);
  assign count   = cnt_q;
endmodule

// File: rtl/wdt_edge_watchdog.sv
module wdt_edge_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TIMEOUT_CYC = CLK_HZ / 10 * 16,
  parameter int unsigned SYNC_STAGES = WDT_SYNC_DEFAULT,
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic wdi_float,
  input  logic supply_ok,
  input  logic sys_rst,
  output logic wdo_n
);
  if (TIMEOUT_CYC < 2) begin : g_bad_timeout
    $error("TIMEOUT_CYC must be at least 2");
  end
  if (SYNC_STAGES < 2) begin : g_bad_sync
    $error("SYNC_STAGES must be at least 2");
  end

  logic          wdi_sync;
  logic          edge_pulse;
  logic          expired;
  logic [CW-1:0] tmr_count;

  wdt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wdi),
    .dout (wdi_sync)
  );

  wdt_edge i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (wdi_sync),
    .toggled(edge_pulse)
  );

  wdt_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle   (wdi_float),
    .clear  (sys_rst | edge_pulse),
    .expired(expired),
    .count  (tmr_count)
  );

  // supply loss forces low; recovery releases without delay
  assign wdo_n = supply_ok & ~expired;
endmodule

// File: rtl/wdt_edge_watchdog_chk.sv
module wdt_edge_watchdog_chk #(
  parameter int unsigned TIMEOUT_CYC = 5,
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wdi_float,
  input logic          supply_ok,
  input logic          sys_rst,
  input logic          wdo_n,
  input logic          expired,
  input logic [CW-1:0] count,
  input logic          edge_seen
);
  AST_EXPIRE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(count) == CW'(TIMEOUT_CYC - 1)); // R1
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen && !wdi_float |=> !expired && count == '0); // R2
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !expired && count == '0); // R4
  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wdi_float |=> !expired); // R5
  AST_EXPIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !edge_seen && !sys_rst && !wdi_float |=> expired); // R6
  AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wdo_n); // R7
endmodule

bind wdt_edge_watchdog wdt_edge_watchdog_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wdi_float(wdi_float),
  .supply_ok(supply_ok),
  .sys_rst  (sys_rst),
  .wdo_n    (wdo_n),
  .expired  (expired),
  .count    (tmr_count),
  .edge_seen(edge_pulse)
);

// File: tb/test_wdt_edge_watchdog.sv
module test_wdt_edge_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int T = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi = 1'b0;
  logic wdi_float = 1'b0;
  logic supply_ok = 1'b1;
  logic sys_rst = 1'b0;
  logic wdo_n;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  bit m1, m2, m3, prev_float;
  int quiet = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_edge_watchdog #(.TIMEOUT_CYC(T)) i_wdt_edge_watchdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdi      (wdi),
    .wdi_float(wdi_float),
    .supply_ok(supply_ok),
    .sys_rst  (sys_rst),
    .wdo_n    (wdo_n)
  );

  function automatic bit model_out();
    return supply_ok && (quiet < T);
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: wdo_n=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic step(input string tag);
    bit clr;
    @(posedge clk);
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; prev_float = 0; quiet = 0;
    end else begin
      clr = sys_rst || wdi_float || prev_float || (m2 ^ m3);
      m3 = m2; m2 = m1; m1 = wdi; prev_float = wdi_float;
      if (clr) quiet = 0;
      else if (quiet < T) quiet++;
    end
    @(negedge clk);
    check(wdo_n, model_out(), tag);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    steps(3, "R11");
    @(negedge clk) rst_n = 1'b1;
    steps(2, "R11");

    // R1 steady low input times out; R6 stays low
    steps(T + 6, "R1");
    steps(4, "R6");

    // R2 / R3 sweep toggle gaps around the window
    for (int gap = 1; gap <= 8; gap++) begin
      for (int k = 0; k < 4; k++) begin
        wdi = ~wdi;
        steps(gap, wdi ? "R2" : "R3");
      end
    end
    steps(T + 2, "R1");

    // R9 latency from a single change while expired
    wdi = ~wdi;
    steps(T + 3, "R9");

    // R4 reset clears expired alarm and blocks timeouts
    steps(T + 2, "R1");
    sys_rst = 1'b1;
    steps(3 * T, "R4");
    sys_rst = 1'b0;
    steps(T + 3, "R4");

    // R5 floating: no timeout; R10 leave float then full window
    wdi_float = 1'b1;
    steps(4 * T, "R5");
    wdi = ~wdi;
    steps(4, "R5");
    wdi_float = 1'b0;
    steps(T + 4, "R10");

    // R7 supply low forces output low
    wdi = ~wdi;
    steps(1, "R7");
    supply_ok = 1'b0;
    #1 check(wdo_n, 1'b0, "R7");
    steps(3, "R7");
    // R8 immediate release on recovery
    supply_ok = 1'b1;
    #1 check(wdo_n, model_out(), "R8");
    steps(T + 3, "R8");

    // supply recovery while expired stays low (R6)
    supply_ok = 1'b0;
    steps(2, "R7");
    supply_ok = 1'b1;
    #1 check(wdo_n, model_out(), "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule